// File: doc/BRIEF.md
# CAN Error Status Register Unit

This block holds the error and status word of a CAN controller and presents it to a host through a small register port. It takes single-cycle bus error pulses from the protocol engine (bit-1, bit-0, acknowledge, CRC, form and stuff errors), a wake-up pulse, two bus activity levels, and the transmit and receive error counters. From these inputs it keeps sticky error flags, warning levels, a fault confinement code and a set of interrupt flags. It then gates those flags with host enable bits to drive one registered error interrupt line.

The host reads three words. Address 0 is the status word. Reading it clears the six bus error flags, and writing ones to it acknowledges the interrupt flags. Address 1 holds the interrupt enables. Address 2 mirrors the two error counters. The protocol engine computes the error counters; this block only compares them against fixed thresholds.

Top module: `err_status_unit`

## Requirements
- R1: Status bit 9 is 1 when the transmit counter is 96 or more, and bit 8 is 1 when the receive counter is 96 or more. Bit 7 mirrors `bus_idle` and bit 6 mirrors `bus_active`. All four appear one clock after the inputs change.
- R2: Status bits 5:4 hold the fault confinement code. The code is 2'b10 (bus off) when the 9-bit transmit counter is 256 or more. Otherwise it is 2'b01 (passive) when either counter is 128 or more. Otherwise it is 2'b00 (active). The value 2'b11 never appears.
- R3: A pulse on `berr_evt[k]` sets status bit 10+k, and that bit stays set. Index 5 is the bit-1 error, 4 the bit-0 error, 3 the acknowledge error, 2 the CRC error, 1 the form error and 0 the stuff error.
- R4: A read of address 0 returns the flags as they were before the read, then clears bits 15:10. If an error pulse arrives in the same cycle as the read, its flag remains set after the read.
- R5: Summary bit 1 sets on any bus error pulse or on any change of the fault confinement code. Writing 1 to bit 1 at address 0 clears it. Writing 0 has no effect. A new set in the same cycle as the clear wins.
- R6: Bits 17, 16 and 2 set on the rising edge of transmit warning, receive warning and bus off respectively. Each clears when 1 is written to its position at address 0. While the condition persists, a cleared flag does not set again.
- R7: A pulse on `wake_evt` sets bit 0. Writing 1 to bit 0 at address 0 clears it.
- R8: The control word at address 1 keeps only the enables for bus off (bit 15), error (bit 14), transmit warning (bit 11), receive warning (bit 10) and wake-up (bit 0). All other bits read 0.
- R9: `err_irq` is registered. It is the OR of: bus off flag AND enable 15; summary flag AND enable 14; wake flag AND enable 0; and, only when enable 14 is set, either warning flag AND its own enable. It follows a flag or enable change by one clock.
- R10: Address 2 returns transmit counter bits 7:0 in bits 7:0 and receive counter bits 7:0 in bits 15:8. The other bits read 0.
- R11: `host_rdata` is valid one clock after `host_rd`. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | AW (2) | Register index |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Registered read data |
| berr_evt | input | 6 | Bus error pulses (bit-1, bit-0, ack, CRC, form, stuff from MSB) |
| wake_evt | input | 1 | Wake-up pulse |
| bus_idle | input | 1 | Bus idle level |
| bus_active | input | 1 | Transmit/receive activity level |
| tx_errcnt | input | TXC_W (9) | Transmit error counter |
| rx_errcnt | input | RXC_W (8) | Receive error counter |
| err_irq | output | 1 | Registered error interrupt |

## Verification
Status levels, the fault code and all flags change on the first clock edge after their cause. The bench therefore drives inputs on the falling edge and reads on the next falling edge. A read strobe placed on one falling edge returns data on the following falling edge, and that data shows the flags from before the read. The interrupt line lags a flag or a control write by one further edge, so interrupt checks wait one extra falling edge after a write completes. The bench sweeps the transmit counter from 0 to 300 and the receive counter from 0 to 255. At each value it compares the status word and the counter word against thresholds the bench computes itself.

// File: rtl/esr_pkg.sv
package esr_pkg;

  // Fault confinement encoding, carried in status bits 5:4
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fault_e;

  typedef struct packed {
    logic   tx_warn;
    logic   rx_warn;
    fault_e fault;
  } conf_t;

  // Register indices
  localparam int ADDR_STAT = 0;
  localparam int ADDR_CTRL = 1;
  localparam int ADDR_CNT  = 2;

  // Status word positions
  localparam int ST_TWRN_IF = 17;
  localparam int ST_RWRN_IF = 16;
  localparam int ST_BERR_LO = 10;
  localparam int ST_TX_WARN = 9;
  localparam int ST_RX_WARN = 8;
  localparam int ST_IDLE    = 7;
  localparam int ST_ACTIVE  = 6;
  localparam int ST_FC_LO   = 4;
  localparam int ST_BOFF_IF = 2;
  localparam int ST_ERR_IF  = 1;
  localparam int ST_WAKE_IF = 0;

  // Control word enable positions
  localparam int EN_BOFF = 15;
  localparam int EN_ERR  = 14;
  localparam int EN_TWRN = 11;
  localparam int EN_RWRN = 10;
  localparam int EN_WAKE = 0;

  localparam logic [31:0] CTRL_MASK =
    (32'd1 << EN_BOFF) | (32'd1 << EN_ERR) | (32'd1 << EN_TWRN) |
    (32'd1 << EN_RWRN) | (32'd1 << EN_WAKE);

  // Interrupt flag vector ordering inside the flag bank
  localparam int IF_TWRN = 4;
  localparam int IF_RWRN = 3;
  localparam int IF_BOFF = 2;
  localparam int IF_ERR  = 1;
  localparam int IF_WAKE = 0;
  localparam int NIF     = 5;

endpackage

// File: rtl/esr_fault_eval.sv
module esr_fault_eval
  import esr_pkg::*;
#(
  parameter int TXC_W    = 9,
  parameter int RXC_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int BOFF_LIM = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TXC_W-1:0] tx_cnt,
  input  logic [RXC_W-1:0] rx_cnt,
  output conf_t            conf_q,
  output logic             twrn_rise,
  output logic             rwrn_rise,
  output logic             boff_rise,
  output logic             conf_chg
);

  localparam logic [TXC_W-1:0] TX_WARN = TXC_W'(WARN_LIM);
  localparam logic [TXC_W-1:0] TX_PASS = TXC_W'(PASS_LIM);
  localparam logic [TXC_W-1:0] TX_BOFF = TXC_W'(BOFF_LIM);
  localparam logic [RXC_W-1:0] RX_WARN = RXC_W'(WARN_LIM);
  localparam logic [RXC_W-1:0] RX_PASS = RXC_W'(PASS_LIM);

  conf_t conf_d;

  always_comb begin
    conf_d.tx_warn = (tx_cnt >= TX_WARN);
    conf_d.rx_warn = (rx_cnt >= RX_WARN);
    if (tx_cnt >= TX_BOFF)
      conf_d.fault = FC_BUSOFF;
    else if ((tx_cnt >= TX_PASS) || (rx_cnt >= RX_PASS))
      conf_d.fault = FC_PASSIVE;
    else
      conf_d.fault = FC_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conf_q <= '{tx_warn: 1'b0, rx_warn: 1'b0, fault: FC_ACTIVE};
    end else begin
      conf_q <= conf_d;
    end
  end

  // Edge events are taken against the registered copy so that flags and
  // levels update on the same clock edge.
  assign twrn_rise = conf_d.tx_warn & ~conf_q.tx_warn;
  assign rwrn_rise = conf_d.rx_warn & ~conf_q.rx_warn;
  assign boff_rise = (conf_d.fault == FC_BUSOFF) && (conf_q.fault != FC_BUSOFF);
  assign conf_chg  = (conf_d.fault != conf_q.fault);

endmodule

// File: rtl/esr_flag_bank.sv
module esr_flag_bank
  import esr_pkg::*;
#(
  parameter int NBERR = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBERR-1:0] berr_evt,
  input  logic             rd_clr,
  input  logic [NIF-1:0]   if_set,
  input  logic [NIF-1:0]   if_w1c,
  output logic [NBERR-1:0] berr_q,
  output logic [NIF-1:0]   if_q
);

  // Bus error flags: a read clears them, a coincident event keeps them set
  for (genvar k = 0; k < NBERR; k++) begin : g_berr
    always_ff @(posedge clk) begin
      if (rst)
        berr_q[k] <= 1'b0;
      else
        berr_q[k] <= berr_evt[k] | (berr_q[k] & ~rd_clr);
    end
  end

  // Interrupt flags: write-one-to-clear, set has priority
  for (genvar j = 0; j < NIF; j++) begin : g_iflag
    always_ff @(posedge clk) begin
      if (rst)
        if_q[j] <= 1'b0;
      else
        if_q[j] <= if_set[j] | (if_q[j] & ~if_w1c[j]);
    end
  end

endmodule

// File: rtl/esr_irq_ctrl.sv
module esr_irq_ctrl
  import esr_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [31:0]    wdata,
  input  logic [NIF-1:0] if_q,
  output logic [31:0]    ctrl_q,
  output logic           irq_q
);

  logic warn_any;
  logic irq_d;

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (wr_en)
      ctrl_q <= wdata & CTRL_MASK;
  end

  // Warning sources are only delivered under the general error enable
  always_comb begin
    warn_any = (if_q[IF_TWRN] & ctrl_q[EN_TWRN]) |
               (if_q[IF_RWRN] & ctrl_q[EN_RWRN]);
    irq_d    = (if_q[IF_BOFF] & ctrl_q[EN_BOFF]) |
               (if_q[IF_ERR]  & ctrl_q[EN_ERR])  |
               (if_q[IF_WAKE] & ctrl_q[EN_WAKE]) |
               (warn_any      & ctrl_q[EN_ERR]);
  end

  always_ff @(posedge clk) begin
    if (rst)
      irq_q <= 1'b0;
    else
      irq_q <= irq_d;
  end

endmodule

// File: rtl/err_status_unit.sv
module err_status_unit
  import esr_pkg::*;
#(
  parameter int AW       = 2,
  parameter int NBERR    = 6,
  parameter int TXC_W    = 9,
  parameter int RXC_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int BOFF_LIM = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    host_addr,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic [NBERR-1:0] berr_evt,
  input  logic             wake_evt,
  input  logic             bus_idle,
  input  logic             bus_active,
  input  logic [TXC_W-1:0] tx_errcnt,
  input  logic [RXC_W-1:0] rx_errcnt,
  output logic             err_irq
);

  localparam logic [AW-1:0] A_STAT = AW'(ADDR_STAT);
  localparam logic [AW-1:0] A_CTRL = AW'(ADDR_CTRL);
  localparam logic [AW-1:0] A_CNT  = AW'(ADDR_CNT);

  conf_t            conf_q;
  logic             twrn_rise, rwrn_rise, boff_rise, conf_chg;
  logic [NBERR-1:0] berr_q;
  logic [NIF-1:0]   if_q, if_set, if_w1c;
  logic [31:0]      ctrl_word;
  logic [31:0]      esr_word;
  logic [31:0]      cnt_word;
  logic             idle_q, active_q;
  logic             sel_stat, sel_ctrl;
  logic             rd_clr;

  assign sel_stat = (host_addr == A_STAT);
  assign sel_ctrl = (host_addr == A_CTRL);
  assign rd_clr   = host_rd & sel_stat;

  esr_fault_eval #(
    .TXC_W   (TXC_W),
    .RXC_W   (RXC_W),
    .WARN_LIM(WARN_LIM),
    .PASS_LIM(PASS_LIM),
    .BOFF_LIM(BOFF_LIM)
  ) u_eval (
    .clk      (clk),
    .rst      (rst),
    .tx_cnt   (tx_errcnt),
    .rx_cnt   (rx_errcnt),
    .conf_q   (conf_q),
    .twrn_rise(twrn_rise),
    .rwrn_rise(rwrn_rise),
    .boff_rise(boff_rise),
    .conf_chg (conf_chg)
  );

  always_comb begin
    if_set          = '0;
    if_set[IF_TWRN] = twrn_rise;
    if_set[IF_RWRN] = rwrn_rise;
    if_set[IF_BOFF] = boff_rise;
    if_set[IF_ERR]  = (|berr_evt) | conf_chg;
    if_set[IF_WAKE] = wake_evt;

    if_w1c          = '0;
    if (host_wr && sel_stat) begin
      if_w1c[IF_TWRN] = host_wdata[ST_TWRN_IF];
      if_w1c[IF_RWRN] = host_wdata[ST_RWRN_IF];
      if_w1c[IF_BOFF] = host_wdata[ST_BOFF_IF];
      if_w1c[IF_ERR]  = host_wdata[ST_ERR_IF];
      if_w1c[IF_WAKE] = host_wdata[ST_WAKE_IF];
    end
  end

  esr_flag_bank #(
    .NBERR(NBERR)
  ) u_flags (
    .clk     (clk),
    .rst     (rst),
    .berr_evt(berr_evt),
    .rd_clr  (rd_clr),
    .if_set  (if_set),
    .if_w1c  (if_w1c),
    .berr_q  (berr_q),
    .if_q    (if_q)
  );

  esr_irq_ctrl u_irq (
    .clk   (clk),
    .rst   (rst),
    .wr_en (host_wr & sel_ctrl),
    .wdata (host_wdata),
    .if_q  (if_q),
    .ctrl_q(ctrl_word),
    .irq_q (err_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      idle_q   <= bus_idle;
      active_q <= bus_active;
    end
  end

  always_comb begin
    esr_word                                 = '0;
    esr_word[ST_TWRN_IF]                     = if_q[IF_TWRN];
    esr_word[ST_RWRN_IF]                     = if_q[IF_RWRN];
    esr_word[ST_BERR_LO +: NBERR]            = berr_q;
    esr_word[ST_TX_WARN]                     = conf_q.tx_warn;
    esr_word[ST_RX_WARN]                     = conf_q.rx_warn;
    esr_word[ST_IDLE]                        = idle_q;
    esr_word[ST_ACTIVE]                      = active_q;
    esr_word[ST_FC_LO +: 2]                  = conf_q.fault;
    esr_word[ST_BOFF_IF]                     = if_q[IF_BOFF];
    esr_word[ST_ERR_IF]                      = if_q[IF_ERR];
    esr_word[ST_WAKE_IF]                     = if_q[IF_WAKE];

    cnt_word        = '0;
    cnt_word[7:0]   = tx_errcnt[7:0];
    cnt_word[15:8]  = rx_errcnt[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      if (sel_stat)
        host_rdata <= esr_word;
      else if (sel_ctrl)
        host_rdata <= ctrl_word;
      else if (host_addr == A_CNT)
        host_rdata <= cnt_word;
      else
        host_rdata <= '0;
    end
  end

endmodule

// File: rtl/esr_checker.sv
module esr_checker #(
  parameter int AW    = 2,
  parameter int NBERR = 6,
  parameter int TXC_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    host_addr,
  input logic             host_rd,
  input logic             host_wr,
  input logic             wbit_err,
  input logic [NBERR-1:0] berr_evt,
  input logic [TXC_W-1:0] tx_errcnt,
  input logic [31:0]      esr_word,
  input logic [31:0]      ctrl_word,
  input logic             conf_chg,
  input logic             err_irq
);

  localparam logic [TXC_W-1:0] BOFF_AT = TXC_W'(256);

  // R3: an error pulse always leaves a flag set
  p_berr_set_r3: assert property (@(posedge clk) disable iff (rst)
    (berr_evt != '0) |=> (esr_word[15:10] != 6'd0));

  // R4: a read with no coincident event clears all bus error flags
  p_rdclr_r4: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == '0 && berr_evt == '0) |=> (esr_word[15:10] == 6'd0));

  // R2: the unused fault code never appears
  p_fault_code_r2: assert property (@(posedge clk) disable iff (rst)
    esr_word[5:4] != 2'b11);

  // R2: a counter at the bus off limit yields bus off next cycle
  p_boff_lvl_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_errcnt >= BOFF_AT) |=> (esr_word[5:4] == 2'b10));

  // R5: acknowledged summary flag clears when nothing sets it
  p_sum_w1c_r5: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == '0 && wbit_err && berr_evt == '0 && !conf_chg)
      |=> !esr_word[1]);

  // R6: entering bus off raises the bus off flag
  p_boff_edge_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(esr_word[5]) |-> esr_word[2]);

  // R9: the interrupt needs some enable set one cycle earlier
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> ($past(ctrl_word) != 32'd0));

endmodule

bind err_status_unit esr_checker #(
  .AW   (AW),
  .NBERR(NBERR),
  .TXC_W(TXC_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .host_addr(host_addr),
  .host_rd  (host_rd),
  .host_wr  (host_wr),
  .wbit_err (host_wdata[1]),
  .berr_evt (berr_evt),
  .tx_errcnt(tx_errcnt),
  .esr_word (esr_word),
  .ctrl_word(ctrl_word),
  .conf_chg (conf_chg),
  .err_irq  (err_irq)
);

// File: tb/sim_err_status_unit.sv
`timescale 1ns/1ps
module sim_err_status_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  host_addr = '0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [5:0]  berr_evt = '0;
  logic        wake_evt = 1'b0;
  logic        bus_idle = 1'b0;
  logic        bus_active = 1'b0;
  logic [8:0]  tx_errcnt = '0;
  logic [7:0]  rx_errcnt = '0;
  logic        err_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  err_status_unit u0 (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .berr_evt(berr_evt), .wake_evt(wake_evt), .bus_idle(bus_idle),
    .bus_active(bus_active), .tx_errcnt(tx_errcnt), .rx_errcnt(rx_errcnt),
    .err_irq(err_irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    host_addr = a; host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic pulse_berr(input logic [5:0] v);
    berr_evt = v;
    @(negedge clk);
    berr_evt = '0;
  endtask

  function automatic logic [1:0] exp_fc(input int tx, input int rx);
    if (tx >= 256) return 2'b10;
    if (tx >= 128 || rx >= 128) return 2'b01;
    return 2'b00;
  endfunction

  task automatic clear_all();
    logic [31:0] d;
    rd(2'd0, d);
    wr(2'd0, 32'h0003_0007);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state
    chk("reset irq R9", {31'd0, err_irq}, 32'd0);
    rd(2'd0, d); chk("reset status R1", d, 32'd0);
    rd(2'd1, d); chk("reset ctrl R8", d, 32'd0);

    // R1, R2, R10: transmit counter sweep
    for (int t = 0; t <= 300; t++) begin
      tx_errcnt = 9'(t); rx_errcnt = 8'd0;
      @(negedge clk);
      rd(2'd0, d);
      chk("R1 tx warn", {31'd0, d[9]}, {31'd0, (t >= 96)});
      chk("R2 fault tx", {30'd0, d[5:4]}, {30'd0, exp_fc(t, 0)});
      rd(2'd2, d);
      chk("R10 cnt tx", d, {16'd0, 8'd0, 8'(t)});
    end
    // R1, R2, R10: receive counter sweep
    for (int r = 0; r <= 255; r++) begin
      tx_errcnt = 9'd0; rx_errcnt = 8'(r);
      @(negedge clk);
      rd(2'd0, d);
      chk("R1 rx warn", {31'd0, d[8]}, {31'd0, (r >= 96)});
      chk("R2 fault rx", {30'd0, d[5:4]}, {30'd0, exp_fc(0, r)});
      rd(2'd2, d);
      chk("R10 cnt rx", d, {16'd0, 8'(r), 8'd0});
    end
    rx_errcnt = 8'd0;
    @(negedge clk);

    // R1: idle and activity mirrors
    bus_idle = 1'b1; bus_active = 1'b0; @(negedge clk);
    rd(2'd0, d); chk("R1 idle", {30'd0, d[7:6]}, 32'd2);
    bus_idle = 1'b0; bus_active = 1'b1; @(negedge clk);
    rd(2'd0, d); chk("R1 active", {30'd0, d[7:6]}, 32'd1);
    bus_active = 1'b0;

    // R3, R4, R5: each bus error source
    clear_all();
    for (int k = 0; k < 6; k++) begin
      pulse_berr(6'd1 << k);
      rd(2'd0, d);
      chk("R3 berr map", {26'd0, d[15:10]}, 32'd1 << k);
      chk("R5 summary set", {31'd0, d[1]}, 32'd1);
      rd(2'd0, d);
      chk("R4 read clear", {26'd0, d[15:10]}, 32'd0);
    end
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, d); chk("R5 write zero keeps", {31'd0, d[1]}, 32'd1);
    wr(2'd0, 32'h0000_0002);
    rd(2'd0, d); chk("R5 w1c", {31'd0, d[1]}, 32'd0);

    // R4: event coincident with a read survives
    pulse_berr(6'b000100);
    berr_evt = 6'b001000;
    rd(2'd0, d);
    berr_evt = '0;
    chk("R4 pre-read view", {26'd0, d[15:10]}, 32'h4);
    rd(2'd0, d);
    chk("R4 coincident kept", {26'd0, d[15:10]}, 32'h8);

    // R5: set wins over a coincident acknowledge
    clear_all();
    berr_evt = 6'b000001;
    wr(2'd0, 32'h0000_0002);
    berr_evt = '0;
    rd(2'd0, d); chk("R5 set wins", {31'd0, d[1]}, 32'd1);

    // R6: rising-edge warning and bus off flags
    clear_all();
    tx_errcnt = 9'd100; @(negedge clk);
    rd(2'd0, d); chk("R6 twrn set", {31'd0, d[17]}, 32'd1);
    wr(2'd0, 32'h0002_0000);
    @(negedge clk);
    rd(2'd0, d); chk("R6 twrn no reset while high", {31'd0, d[17]}, 32'd0);
    tx_errcnt = 9'd0; @(negedge clk);
    tx_errcnt = 9'd100; @(negedge clk);
    rd(2'd0, d); chk("R6 twrn new edge", {31'd0, d[17]}, 32'd1);
    rx_errcnt = 8'd100; @(negedge clk);
    rd(2'd0, d); chk("R6 rwrn set", {31'd0, d[16]}, 32'd1);
    tx_errcnt = 9'd260; @(negedge clk);
    rd(2'd0, d); chk("R6 boff set", {31'd0, d[2]}, 32'd1);
    wr(2'd0, 32'h0000_0004);
    rd(2'd0, d); chk("R6 boff w1c", {31'd0, d[2]}, 32'd0);
    tx_errcnt = 9'd0; rx_errcnt = 8'd0; @(negedge clk);

    // R7: wake flag
    clear_all();
    wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
    rd(2'd0, d); chk("R7 wake set", {31'd0, d[0]}, 32'd1);
    wr(2'd0, 32'h0000_0001);
    rd(2'd0, d); chk("R7 wake w1c", {31'd0, d[0]}, 32'd0);

    // R8: control masking
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R8 ctrl mask", d, 32'h0000_CC01);
    wr(2'd1, 32'h0);
    rd(2'd1, d); chk("R8 ctrl zero", d, 32'h0);

    // R11: unmapped address
    rd(2'd3, d); chk("R11 unmapped", d, 32'h0);

    // R9: interrupt gating
    clear_all();
    tx_errcnt = 9'd100; @(negedge clk);
    wr(2'd1, 32'h0000_0800); @(negedge clk);
    chk("R9 warn needs general enable", {31'd0, err_irq}, 32'd0);
    wr(2'd1, 32'h0000_4800); @(negedge clk);
    chk("R9 warn delivered", {31'd0, err_irq}, 32'd1);
    wr(2'd0, 32'h0002_0000); @(negedge clk);
    chk("R9 warn acked", {31'd0, err_irq}, 32'd0);
    wr(2'd1, 32'h0000_8000);
    tx_errcnt = 9'd260; @(negedge clk); @(negedge clk);
    chk("R9 boff irq", {31'd0, err_irq}, 32'd1);
    tx_errcnt = 9'd0; @(negedge clk);
    clear_all(); @(negedge clk);
    chk("R9 boff acked", {31'd0, err_irq}, 32'd0);
    wr(2'd1, 32'h0000_0001);
    wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0; @(negedge clk);
    chk("R9 wake irq", {31'd0, err_irq}, 32'd1);
    wr(2'd1, 32'h0); @(negedge clk);
    chk("R9 disabled", {31'd0, err_irq}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule